// File: doc/BRIEF.md
# Half-Duplex Command-Response Serial Master

This block is the master end of a three-wire-plus-select serial link on which every exchange is split in time. The master first sends an 8-bit command to the slave, MSB first. One idle serial clock follows. The slave then returns a response whose length is set between 4 and 16 bits. The data line that faces out carries only the command. The line that faces in is sampled only during the response. The two directions never overlap.

A command is offered on a valid/ready pair and is accepted only while the master is idle. The response length and the serial-clock divider are captured when the command is accepted. The finished response word appears right-aligned on `rsp_data` with a single-cycle `rsp_valid` strobe. The master then drops back to idle with the serial clock low and the select line high.

Top module: `cmdrsp_serial_master`

## Requirements
- R1: The command goes out MSB first as 8 bits on `txd`. `txd` changes only while `sclk` is low, so the slave takes each bit on a rising `sclk` edge.
- R2: Values on `rxd` during the command and turnaround periods have no effect on the response word.
- R3: After the 8th command period there is one full serial period in which nothing is sampled. `txd` is held at 0 for this turnaround period and for all response periods.
- R4: The response length L is captured from `rsp_len` at acceptance. A value below 4 is used as 4 and a value above 16 is used as 16.
- R5: A frame has exactly 9+L rising `sclk` edges, which is 13 to 25.
- R6: `sel_n` falls on the acceptance edge. The first rising `sclk` edge follows `div_half`+1 clock cycles later. `sel_n` rises on the final falling `sclk` edge, which comes after the last response bit has been sampled. `sclk` only rises while `sel_n` is low.
- R7: Response bits are sampled on rising `sclk` edges, MSB first. They are right-aligned in `rsp_data`, and the bits above L are 0. `rsp_valid` is high for exactly one cycle, on the edge where `sel_n` rises. `rsp_data` then holds until the next acceptance.
- R8: After reset and whenever the master is idle: `sclk` is 0, `sel_n` is 1, `txd` is 0 and `busy` is 0.
- R9: Each half of a serial period lasts `div_half`+1 clock cycles. `div_half` is captured at acceptance, so a frame lasts 2·(9+L)·(`div_half`+1) cycles.
- R10: A command is accepted when `cmd_valid` and `cmd_ready` are both high, where `cmd_ready` is the inverse of `busy`. `busy` stays high from acceptance through the final edge. `cmd_valid` or setting changes raised during a frame have no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | A command is offered |
| cmd_data | input | CMD_W (8) | Command byte |
| cmd_ready | output | 1 | Master is idle and takes a command |
| rsp_len | input | LEN_W (5) | Response length request, clamped to 4..16 |
| div_half | input | DIV_W (8) | Half serial period minus one, in clock cycles |
| rsp_valid | output | 1 | One-cycle strobe: response complete |
| rsp_data | output | RSP_MAX (16) | Right-aligned response word |
| busy | output | 1 | Frame in progress |
| sclk | output | 1 | Serial clock, idle low |
| sel_n | output | 1 | Active-low slave select |
| txd | output | 1 | Command data to the slave |
| rxd | input | 1 | Response data from the slave |

## Verification
The bench's slave model toggles `rxd` on every falling edge outside the response window. A master that sampled during the command or the turnaround would then return a word that differs from the expected one. This matters most for an all-zero response. The shortest length (L=4 at the fastest divider), the longest length (L=16), and out-of-range lengths that must clamp are each run. An off-by-one in the period counter would show up as a wrong rising-edge count or a wrong frame duration. In one frame, a second command is offered mid-frame and the length and divider inputs are changed at the same time. A master that did not latch its settings, or that accepted while busy, would stretch the frame, shift the response, or start a second frame.

// File: rtl/cmdrsp_pkg.sv
package cmdrsp_pkg;
   typedef enum logic [1:0] {
      PH_IDLE = 2'd0,
      PH_CMD  = 2'd1,
      PH_TURN = 2'd2,
      PH_RSP  = 2'd3
   } cr_phase_e;
endpackage

// File: rtl/cmdrsp_halftick.sv
module cmdrsp_halftick #(
   parameter int DIV_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic [DIV_W-1:0] div_q,
   output logic             tick
);
   logic [DIV_W-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)             cnt <= '0;
      else if (!run)          cnt <= '0;
      else if (cnt == div_q)  cnt <= '0;
      else                    cnt <= cnt + 1'b1;
   end

   assign tick = run && (cnt == div_q);
endmodule

// File: rtl/cmdrsp_seq.sv
module cmdrsp_seq
   import cmdrsp_pkg::*;
#(
   parameter int CMD_W   = 8,
   parameter int RSP_MAX = 16,
   parameter int LEN_W   = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             start,
   input  logic [LEN_W-1:0] len_eff,
   input  logic             tick,
   output logic             sclk,
   output logic             sel_n,
   output logic             busy,
   output logic             sample,
   output logic             advance,
   output logic             done
);
   localparam int PCNT_W = $clog2(CMD_W + RSP_MAX + 1);
   localparam logic [PCNT_W-1:0] P_TURN = PCNT_W'(CMD_W);
   localparam logic [PCNT_W-1:0] P_RSP  = PCNT_W'(CMD_W + 1);

   cr_phase_e         phase;
   logic              half;
   logic [PCNT_W-1:0] pcnt;
   logic [PCNT_W-1:0] last_q;
   logic [PCNT_W-1:0] pcnt_nx;
   logic              at_last;

   assign pcnt_nx = pcnt + 1'b1;
   assign at_last = (pcnt == last_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         phase  <= PH_IDLE;
         half   <= 1'b0;
         pcnt   <= '0;
         last_q <= '0;
         sclk   <= 1'b0;
         sel_n  <= 1'b1;
         done   <= 1'b0;
      end else begin
         done <= 1'b0;
         if (phase == PH_IDLE) begin
            if (start) begin
               phase  <= PH_CMD;
               half   <= 1'b0;
               pcnt   <= '0;
               sclk   <= 1'b0;
               sel_n  <= 1'b0;
               last_q <= PCNT_W'(CMD_W) + PCNT_W'(len_eff);
            end
         end else if (tick) begin
            if (!half) begin
               half <= 1'b1;
               sclk <= 1'b1;
            end else begin
               half <= 1'b0;
               sclk <= 1'b0;
               if (at_last) begin
                  phase <= PH_IDLE;
                  sel_n <= 1'b1;
                  done  <= 1'b1;
               end else begin
                  pcnt <= pcnt_nx;
                  if (pcnt_nx == P_TURN)     phase <= PH_TURN;
                  else if (pcnt_nx == P_RSP) phase <= PH_RSP;
               end
            end
         end
      end
   end

   assign busy    = (phase != PH_IDLE);
   assign sample  = tick && !half && (phase == PH_RSP);
   assign advance = tick && half && busy && !at_last;
endmodule

// File: rtl/cmdrsp_txshift.sv
module cmdrsp_txshift #(
   parameter int W = 8
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] din,
   input  logic         shift,
   output logic         txd
);
   logic [W-1:0] sr;

   for (genvar i = 0; i < W; i++) begin : g_bit
      if (i == 0) begin : g_lsb
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)     sr[i] <= 1'b0;
            else if (load)  sr[i] <= din[i];
            else if (shift) sr[i] <= 1'b0;
         end
      end else begin : g_upper
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)     sr[i] <= 1'b0;
            else if (load)  sr[i] <= din[i];
            else if (shift) sr[i] <= sr[i-1];
         end
      end
   end

   assign txd = sr[W-1];
endmodule

// File: rtl/cmdrsp_rxshift.sv
module cmdrsp_rxshift #(
   parameter int W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         clear,
   input  logic         shift,
   input  logic         rxd,
   output logic [W-1:0] data
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     data <= '0;
      else if (clear) data <= '0;
      else if (shift) data <= {data[W-2:0], rxd};
   end
endmodule

// File: rtl/cmdrsp_serial_master.sv
module cmdrsp_serial_master #(
   parameter int CMD_W   = 8,
   parameter int RSP_MIN = 4,
   parameter int RSP_MAX = 16,
   parameter int DIV_W   = 8,
   localparam int LEN_W  = $clog2(RSP_MAX + 1)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               cmd_valid,
   input  logic [CMD_W-1:0]   cmd_data,
   output logic               cmd_ready,
   input  logic [LEN_W-1:0]   rsp_len,
   input  logic [DIV_W-1:0]   div_half,
   output logic               rsp_valid,
   output logic [RSP_MAX-1:0] rsp_data,
   output logic               busy,
   output logic               sclk,
   output logic               sel_n,
   output logic               txd,
   input  logic               rxd
);
   if (CMD_W < 1)                          begin : g_bad_cmd $error("CMD_W must be at least 1"); end
   if (RSP_MIN < 2 || RSP_MAX < RSP_MIN)   begin : g_bad_len $error("need 2 <= RSP_MIN <= RSP_MAX"); end
   if (DIV_W < 1)                          begin : g_bad_div $error("DIV_W must be at least 1"); end

   logic             accept;
   logic             tick;
   logic             sample;
   logic             advance;
   logic [LEN_W-1:0] len_eff;
   logic [DIV_W-1:0] div_q;

   assign cmd_ready = !busy;
   assign accept    = cmd_valid && cmd_ready;

   if (RSP_MIN == RSP_MAX) begin : g_fixed_len
      assign len_eff = LEN_W'(RSP_MAX);
   end else begin : g_clamp_len
      always_comb begin
         if (rsp_len < LEN_W'(RSP_MIN))      len_eff = LEN_W'(RSP_MIN);
         else if (rsp_len > LEN_W'(RSP_MAX)) len_eff = LEN_W'(RSP_MAX);
         else                                len_eff = rsp_len;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      div_q <= '0;
      else if (accept) div_q <= div_half;
   end

   cmdrsp_halftick #(.DIV_W(DIV_W)) u_tick (
      .clk   (clk),
      .rst_n (rst_n),
      .run   (busy),
      .div_q (div_q),
      .tick  (tick)
   );

   cmdrsp_seq #(.CMD_W(CMD_W), .RSP_MAX(RSP_MAX), .LEN_W(LEN_W)) u_seq (
      .clk     (clk),
      .rst_n   (rst_n),
      .start   (accept),
      .len_eff (len_eff),
      .tick    (tick),
      .sclk    (sclk),
      .sel_n   (sel_n),
      .busy    (busy),
      .sample  (sample),
      .advance (advance),
      .done    (rsp_valid)
   );

   cmdrsp_txshift #(.W(CMD_W)) u_tx (
      .clk   (clk),
      .rst_n (rst_n),
      .load  (accept),
      .din   (cmd_data),
      .shift (advance),
      .txd   (txd)
   );

   cmdrsp_rxshift #(.W(RSP_MAX)) u_rx (
      .clk   (clk),
      .rst_n (rst_n),
      .clear (accept),
      .shift (sample),
      .rxd   (rxd),
      .data  (rsp_data)
   );
endmodule

// File: rtl/cmdrsp_sva.sv
module cmdrsp_sva #(
   parameter int RSP_MAX = 16
) (
   input logic               clk,
   input logic               rst_n,
   input logic               sclk,
   input logic               sel_n,
   input logic               txd,
   input logic               busy,
   input logic               cmd_ready,
   input logic               rsp_valid,
   input logic [RSP_MAX-1:0] rsp_data
);
   AST_TXD_STILL_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
      sclk |-> $stable(txd)); // R1

   AST_SCLK_RISE_SELECTED: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(sclk) |-> !sel_n); // R6

   AST_IDLE_PINS: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (!sclk && sel_n && !txd)); // R8

   AST_VALID_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |=> !rsp_valid); // R7

   AST_VALID_ENDS_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |-> (!busy && $past(busy) && sel_n)); // R7

   AST_NO_READY_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> !cmd_ready); // R10

   AST_RSP_HELD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && !$past(busy)) |-> $stable(rsp_data)); // R7
endmodule

bind cmdrsp_serial_master cmdrsp_sva #(.RSP_MAX(RSP_MAX)) u_sva (.*);

// File: tb/tb_cmdrsp_serial_master.sv
module tb_cmdrsp_serial_master;
   localparam int CMD_W   = 8;
   localparam int RSP_MAX = 16;
   localparam int LEN_W   = 5;
   localparam int DIV_W   = 8;

   logic               clk = 1'b0;
   logic               rst_n = 1'b0;
   logic               cmd_valid = 1'b0;
   logic [CMD_W-1:0]   cmd_data = '0;
   logic               cmd_ready;
   logic [LEN_W-1:0]   rsp_len = 5'd8;
   logic [DIV_W-1:0]   div_half = '0;
   logic               rsp_valid;
   logic [RSP_MAX-1:0] rsp_data;
   logic               busy, sclk, sel_n, txd;
   logic               rxd = 1'b0;

   int n_cmp = 0;
   int n_bad = 0;

   always #10 clk = ~clk;

   cmdrsp_serial_master dut (
      .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_data(cmd_data),
      .cmd_ready(cmd_ready), .rsp_len(rsp_len), .div_half(div_half),
      .rsp_valid(rsp_valid), .rsp_data(rsp_data), .busy(busy), .sclk(sclk),
      .sel_n(sel_n), .txd(txd), .rxd(rxd)
   );

   // slave model
   int          rise_cnt = 0;
   int          fall_cnt = 0;
   int          txd_bad = 0;
   int          slave_len = 8;
   logic [7:0]  cap_cmd = '0;
   logic [15:0] slave_rsp = '0;

   always @(negedge sel_n) begin
      rise_cnt = 0; fall_cnt = 0; txd_bad = 0; cap_cmd = '0; rxd = 1'b1;
   end
   always @(posedge sclk) begin
      if (rise_cnt < 8) cap_cmd = {cap_cmd[6:0], txd};
      else if (txd !== 1'b0) txd_bad++;
      rise_cnt++;
   end
   always @(negedge sclk) begin
      fall_cnt++;
      if (fall_cnt >= 9 && fall_cnt - 9 < slave_len)
         rxd = slave_rsp[slave_len - 1 - (fall_cnt - 9)];
      else
         rxd = ~rxd;
   end

   task automatic check(input string req, input string what, input int act, input int exp);
      n_cmp++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   function automatic int clamp_len(input int l);
      if (l < 4)  return 4;
      if (l > 16) return 16;
      return l;
   endfunction

   task automatic t_reset();
      @(negedge clk);
      check("R8", "reset sclk", int'(sclk), 0);
      check("R8", "reset sel_n", int'(sel_n), 1);
      check("R8", "reset txd", int'(txd), 0);
      check("R8", "reset busy", int'(busy), 0);
      check("R7", "reset rsp_valid", int'(rsp_valid), 0);
      rst_n = 1'b1;
      @(negedge clk);
      check("R10", "ready after reset", int'(cmd_ready), 1);
   endtask

   task automatic do_frame(input logic [7:0] cmd, input int len_in, input logic [15:0] rsp,
                           input int div, input bit inject, input string tag);
      int eff = clamp_len(len_in);
      logic [15:0] exp_data = rsp & ((16'h1 << eff) - 16'h1);
      int cyc = 1;
      int first_rise = 0;
      int busy_drop = 0;
      @(negedge clk);
      div_half = DIV_W'(div); rsp_len = LEN_W'(len_in);
      slave_len = eff; slave_rsp = rsp;
      cmd_data = cmd; cmd_valid = 1'b1;
      check("R10", {tag, " ready before accept"}, int'(cmd_ready), 1);
      @(negedge clk);
      cmd_valid = 1'b0;
      check("R10", {tag, " busy after accept"}, int'(busy), 1);
      check("R6", {tag, " sel_n low after accept"}, int'(sel_n), 0);
      while (!rsp_valid && cyc < 20000) begin
         if (first_rise == 0 && sclk) first_rise = cyc;
         if (!busy) busy_drop++;
         if (inject && cyc == 5) begin
            cmd_valid = 1'b1; cmd_data = ~cmd;
            div_half = DIV_W'(div + 2); rsp_len = LEN_W'(len_in + 3);
         end else if (inject && cyc == 6) begin
            cmd_valid = 1'b0;
         end
         @(negedge clk);
         cyc++;
      end
      check("R6", {tag, " cycles to first sclk rise"}, first_rise, div + 2);
      check("R9", {tag, " frame duration"}, cyc, 2 * (9 + eff) * (div + 1) + 1);
      check("R10", {tag, " busy drops mid-frame"}, busy_drop, 0);
      check("R5", {tag, " sclk rising edges"}, rise_cnt, 9 + eff);
      check("R1", {tag, " command seen by slave"}, int'(cap_cmd), int'(cmd));
      check("R3", {tag, " txd nonzero after command"}, txd_bad, 0);
      check("R7", {tag, " response word"}, int'(rsp_data), int'(exp_data));
      check("R6", {tag, " sel_n high at valid"}, int'(sel_n), 1);
      check("R8", {tag, " idle pins at valid"}, int'({sclk, busy}), 0);
      @(negedge clk);
      check("R7", {tag, " valid one cycle"}, int'(rsp_valid), 0);
      check("R7", {tag, " response held"}, int'(rsp_data), int'(exp_data));
      if (inject) begin
         for (int k = 0; k < 12; k++) begin
            if (sel_n !== 1'b1 || busy !== 1'b0) busy_drop++;
            @(negedge clk);
         end
         check("R10", {tag, " no frame from busy-time offer"}, busy_drop, 0);
      end
   endtask

   task automatic t_basic();     do_frame(8'hA5, 8, 16'h003C, 1, 1'b0, "basic");      endtask
   task automatic t_min_fast();  do_frame(8'h81, 4, 16'h000B, 0, 1'b0, "R4 min len");  endtask
   task automatic t_max();       do_frame(8'h5E, 16, 16'hBEEF, 3, 1'b0, "R4 max len"); endtask
   task automatic t_clamp_lo();  do_frame(8'h3C, 2, 16'h0005, 0, 1'b0, "R4 clamp low"); endtask
   task automatic t_clamp_hi();  do_frame(8'hC3, 20, 16'hF00D, 0, 1'b0, "R4 clamp high"); endtask
   task automatic t_ignore_rx(); do_frame(8'hFF, 8, 16'h0000, 1, 1'b0, "R2 zero rsp");  endtask
   task automatic t_busy_offer(); do_frame(8'h69, 6, 16'h002D, 2, 1'b1, "R10 R9 busy offer"); endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      t_reset();
      t_basic();
      t_min_fast();
      t_max();
      t_clamp_lo();
      t_clamp_hi();
      t_ignore_rx();
      t_busy_offer();
      repeat (4) @(negedge clk);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end
endmodule